// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block moves a stereo pair of 24-bit two's complement samples out on one serial data line, framed by a bit clock and a left/right frame clock. It sits behind the decimation stage of an audio converter. It tells that stage, with a one-cycle strobe, when it takes a new sample pair. Everything runs on a single master clock.

As a clock master, the block makes the bit clock and frame clock itself. It divides the master clock by a ratio picked from one of three speed classes. Each frame holds a fixed number of bit slots, split evenly between the two channels. As a clock slave, it follows a bit clock and frame clock supplied from outside. Both are resynchronised into the master clock domain, and frames of any length that holds the data are accepted. A single configuration input picks left-justified or I2S framing. Configuration inputs are meant to be changed only while reset is asserted.

Top module: `audio_serial_tx`

## Requirements
- R1: While reset is asserted and until the first bit-clock edge, bclkOut is 1, lrckOut is 0, sdataOut is 0 and loadStrobe is 0.
- R2: With fmtI2s = 0 (left-justified), the left sample is sent while the frame clock is high. The sample's MSB leaves on the same bit-clock fall that changes the frame clock, followed by the rest of the 24 bits, MSB first.
- R3: sdataOut changes only on a master-clock edge where the bit clock falls: the internal fall in master mode, or the detected external fall in slave mode.
- R4: With fmtI2s = 1 (I2S), the left sample is sent while the frame clock is low. The first bit slot after each frame-clock change carries 0, and the MSB follows one bit clock later.
- R5: Every bit slot of a half-frame after the 24 data bits is driven as 0.
- R6: With masterMode = 1, the bit clock has a 50% duty cycle. Each level lasts BCLK_HALF_QUAD master clocks multiplied by 4, 2 or 1 for speedSel = 0, 1 or 2 (speedSel = 3 acts as 2). The frame clock holds each level for HALF_SLOTS bit clocks and changes only when the bit clock falls.
- R7: Both channel inputs are captured at the master-clock edge that ends the single cycle in which loadStrobe is high. That cycle is the start of the left half-frame. Later input changes wait for the next frame.
- R8: With masterMode = 0, the data follows sclkIn and lrckIn after resynchronisation, for half-frames of 32 or 64 bit clocks, while bclkOut stays 1 and lrckOut stays 0.
- R9: In slave mode, a new frame (and one loadStrobe pulse) begins at the first sclkIn fall after lrckIn has moved to the left-channel level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| fmtI2s | input | 1 | 0 = left-justified, 1 = I2S |
| speedSel | input | 2 | Master divider class: 0 single, 1 double, 2/3 quad |
| leftSample | input | SAMPLE_W | Left channel sample, two's complement |
| rightSample | input | SAMPLE_W | Right channel sample, two's complement |
| sclkIn | input | 1 | External bit clock (slave mode) |
| lrckIn | input | 1 | External frame clock (slave mode) |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| lrckOut | output | 1 | Generated frame clock (master mode) |
| sdataOut | output | 1 | Serial data |
| loadStrobe | output | 1 | One-cycle pulse: sample pair taken at the end of this cycle |

## Verification
The bench builds the block with BCLK_HALF_QUAD = 2 and keeps the other parameters at their defaults. This gives bit-clock half-periods of 8, 4 and 2 master clocks across the three speed classes. The speed-class decode and the divider wrap are therefore both exercised, and a frame stays short enough to run many frames per mode. Slave runs use external half-periods of 8 master clocks, which leaves room for the synchroniser delay. They cover half-frames of both 32 and 64 bit clocks, so the zero tail beyond the 24 data bits is seen in both lengths.

// File: rtl/ast_pkg.sv
package ast_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_QUAD_B = 2'd3
  } ast_speed_e;

  // Strobes handed from the clock/frame control to the shift datapath.
  typedef struct packed {
    logic fall;       // bit clock falls at the coming master-clock edge
    logic halfStart;  // that fall opens a new half-frame
    logic leftHalf;   // the slot belongs to the left channel
  } ast_strobe_t;

endpackage

// File: rtl/ast_sync.sv
module ast_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ast_clk_ctrl.sv
module ast_clk_ctrl
  import ast_pkg::*;
#(
  parameter int BCLK_HALF_QUAD = 1,
  parameter int HALF_SLOTS     = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        masterMode,
  input  logic        fmtI2s,
  input  logic [1:0]  speedSel,
  input  logic        sclkIn,
  input  logic        lrckIn,
  output logic        bclkOut,
  output logic        lrckOut,
  output ast_strobe_t strobe
);

  localparam int MAX_HALF    = 4 * BCLK_HALF_QUAD;
  localparam int DIV_W       = $clog2(MAX_HALF + 1);
  localparam int FRAME_SLOTS = 2 * HALF_SLOTS;
  localparam int IDX_W       = $clog2(FRAME_SLOTS);

  // ---------------- master clock generation ----------------
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLen;
  logic [IDX_W-1:0] masterIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             bclkReg;
  logic             lrckReg;
  logic             divWrap;
  logic             masterFall;
  logic             masterLeft;
  logic             masterHalfStart;

  always_comb begin
    case (ast_speed_e'(speedSel))
      SPD_SINGLE: halfLen = DIV_W'(4 * BCLK_HALF_QUAD);
      SPD_DOUBLE: halfLen = DIV_W'(2 * BCLK_HALF_QUAD);
      default:    halfLen = DIV_W'(BCLK_HALF_QUAD);
    endcase
  end

  assign divWrap         = (divCnt == halfLen - 1'b1);
  assign masterFall      = masterMode && divWrap && bclkReg;
  assign nextIdx         = (masterIdx == IDX_W'(FRAME_SLOTS - 1)) ? '0 : masterIdx + 1'b1;
  assign masterLeft      = (nextIdx < IDX_W'(HALF_SLOTS));
  assign masterHalfStart = (nextIdx == '0) || (nextIdx == IDX_W'(HALF_SLOTS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      bclkReg   <= 1'b1;
      lrckReg   <= 1'b0;
      masterIdx <= IDX_W'(FRAME_SLOTS - 1);
    end else if (!masterMode) begin
      divCnt    <= '0;
      bclkReg   <= 1'b1;
      lrckReg   <= 1'b0;
      masterIdx <= IDX_W'(FRAME_SLOTS - 1);
    end else if (divWrap) begin
      divCnt  <= '0;
      bclkReg <= ~bclkReg;
      if (bclkReg) begin
        masterIdx <= nextIdx;
        lrckReg   <= masterLeft ^ fmtI2s;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign bclkOut = bclkReg;
  assign lrckOut = lrckReg;

  // ---------------- slave clock tracking ----------------
  logic sclkS;
  logic lrckS;
  logic sclkPrev;
  logic lastLeft;
  logic slaveFall;
  logic slaveLeft;
  logic slaveHalfStart;

  ast_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncSclk (
    .clk(clk), .rstN(rstN), .d(sclkIn), .q(sclkS)
  );
  ast_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncLrck (
    .clk(clk), .rstN(rstN), .d(lrckIn), .q(lrckS)
  );

  assign slaveFall      = !masterMode && sclkPrev && !sclkS;
  assign slaveLeft      = lrckS ^ fmtI2s;
  assign slaveHalfStart = (slaveLeft != lastLeft);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      lastLeft <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (slaveFall) begin
        lastLeft <= slaveLeft;
      end
    end
  end

  // ---------------- strobes to datapath ----------------
  always_comb begin
    strobe.fall      = masterFall | slaveFall;
    strobe.halfStart = masterMode ? masterHalfStart : slaveHalfStart;
    strobe.leftHalf  = masterMode ? masterLeft : slaveLeft;
  end

  // R6: the frame clock moves only together with a bit-clock fall
  a_r6_lrck_on_bclk_fall: assert property (
    @(posedge clk) disable iff (!rstN)
    !$stable(lrckReg) |-> $fell(bclkReg)
  );

  // R8: generated clock pins sit idle while following external clocks
  a_r8_slave_pins_idle: assert property (
    @(posedge clk) disable iff (!rstN)
    !masterMode |=> (bclkOut && !lrckOut)
  );

endmodule

// File: rtl/ast_shift_dp.sv
module ast_shift_dp
  import ast_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fmtI2s,
  input  ast_strobe_t         strobe,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                sdataOut,
  output logic                loadStrobe
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] rightHold;
  logic [SAMPLE_W-1:0] word;
  logic                sdataReg;

  assign loadStrobe = strobe.fall && strobe.halfStart && strobe.leftHalf;
  assign word       = strobe.leftHalf ? leftSample : rightHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rightHold <= '0;
      sdataReg  <= 1'b0;
    end else if (strobe.fall) begin
      if (strobe.halfStart) begin
        if (strobe.leftHalf) begin
          rightHold <= rightSample;
        end
        if (fmtI2s) begin
          sdataReg <= 1'b0;
          shiftReg <= word;
        end else begin
          sdataReg <= word[SAMPLE_W-1];
          shiftReg <= {word[SAMPLE_W-2:0], 1'b0};
        end
      end else begin
        sdataReg <= shiftReg[SAMPLE_W-1];
        shiftReg <= {shiftReg[SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  assign sdataOut = sdataReg;

  // R3: the data line holds unless a bit-clock fall was signalled
  a_r3_data_on_fall: assert property (
    @(posedge clk) disable iff (!rstN)
    !strobe.fall |=> $stable(sdataOut)
  );

  // R2 / R4: first slot of a frame carries the MSB (left-justified) or 0 (I2S)
  a_r2_first_slot: assert property (
    @(posedge clk) disable iff (!rstN)
    loadStrobe |=> (sdataOut == (fmtI2s ? 1'b0 : $past(leftSample[SAMPLE_W-1])))
  );

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import ast_pkg::*;
#(
  parameter int SAMPLE_W       = 24,
  parameter int HALF_SLOTS     = 32,
  parameter int BCLK_HALF_QUAD = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterMode,
  input  logic                fmtI2s,
  input  logic [1:0]          speedSel,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                sclkIn,
  input  logic                lrckIn,
  output logic                bclkOut,
  output logic                lrckOut,
  output logic                sdataOut,
  output logic                loadStrobe
);

  ast_strobe_t strobe;

  ast_clk_ctrl #(
    .BCLK_HALF_QUAD(BCLK_HALF_QUAD),
    .HALF_SLOTS    (HALF_SLOTS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterMode(masterMode),
    .fmtI2s    (fmtI2s),
    .speedSel  (speedSel),
    .sclkIn    (sclkIn),
    .lrckIn    (lrckIn),
    .bclkOut   (bclkOut),
    .lrckOut   (lrckOut),
    .strobe    (strobe)
  );

  ast_shift_dp #(
    .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fmtI2s     (fmtI2s),
    .strobe     (strobe),
    .leftSample (leftSample),
    .rightSample(rightSample),
    .sdataOut   (sdataOut),
    .loadStrobe (loadStrobe)
  );

endmodule

// File: tb/sim_audio_serial_tx.sv
module sim_audio_serial_tx;

  localparam int SW = 24;
  localparam int BH = 2;
  localparam int HS = 32;
  localparam int P  = 8;   // slave half-period of the external bit clock, in master clocks

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          masterMode = 1'b1;
  logic          fmtI2s = 1'b0;
  logic [1:0]    speedSel = 2'd2;
  logic [SW-1:0] leftSample = '0;
  logic [SW-1:0] rightSample = '0;
  logic          sclkIn = 1'b1;
  logic          lrckIn = 1'b0;
  logic          bclkOut, lrckOut, sdataOut, loadStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  audio_serial_tx #(.SAMPLE_W(SW), .HALF_SLOTS(HS), .BCLK_HALF_QUAD(BH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .fmtI2s(fmtI2s), .speedSel(speedSel),
    .leftSample(leftSample), .rightSample(rightSample), .sclkIn(sclkIn), .lrckIn(lrckIn),
    .bclkOut(bclkOut), .lrckOut(lrckOut), .sdataOut(sdataOut), .loadStrobe(loadStrobe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference for master mode ----------------
  bit  modelOn = 1'b0;
  int  mH = 2, mCnt = 0, mIdx = 2*HS-1;
  bit  mBclk = 1'b1, mLrck = 1'b0, mSd = 1'b0, mFell = 1'b0, mZero = 1'b0;
  logic [SW-1:0] capL = '0, capR = '0;

  function automatic bit slotBit(input logic [SW-1:0] w, input int pos, input bit i2s);
    if (i2s) return (pos >= 1 && pos <= SW) ? w[SW-pos] : 1'b0;
    return (pos < SW) ? w[SW-1-pos] : 1'b0;
  endfunction

  always @(posedge clk) begin
    mFell = 1'b0;
    if (!rstN || !modelOn) begin
      mCnt = 0; mIdx = 2*HS-1; mBclk = 1'b1; mLrck = 1'b0; mSd = 1'b0; mZero = 1'b0;
    end else if (mCnt == mH-1) begin
      mCnt = 0;
      mBclk = !mBclk;
      if (!mBclk) begin
        int pos;
        bit left;
        mFell = 1'b1;
        mIdx = (mIdx + 1) % (2*HS);
        pos = mIdx % HS;
        left = (mIdx < HS);
        mLrck = left ^ fmtI2s;
        if (mIdx == 0) begin capL = leftSample; capR = rightSample; end
        mSd = slotBit(left ? capL : capR, pos, fmtI2s);
        mZero = fmtI2s ? (pos == 0 || pos > SW) : (pos >= SW);
      end
    end else begin
      mCnt++;
    end
  end

  bit prevSd = 1'b0;
  int slaveLoads = 0;
  always @(negedge clk) begin
    if (loadStrobe) slaveLoads++;
    if (modelOn && rstN) begin
      bit expLoad;
      expLoad = (mCnt == mH-1) && mBclk && (mIdx == 2*HS-1);
      chk(bclkOut == mBclk, "R6", "bclkOut", bclkOut, mBclk);
      chk(lrckOut == mLrck, fmtI2s ? "R4" : "R2", "lrckOut", lrckOut, mLrck);
      chk(sdataOut == mSd, mZero ? "R5" : (fmtI2s ? "R4" : "R2"), "sdataOut", sdataOut, mSd);
      chk(loadStrobe == expLoad, "R7", "loadStrobe", loadStrobe, expLoad);
      if (!mFell) chk(sdataOut == prevSd, "R3", "sdataOut held", sdataOut, prevSd);
    end
    prevSd = sdataOut;
  end

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nextSeed(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic runMaster(input bit fmt, input logic [1:0] spd, input int frames);
    @(negedge clk);
    rstN = 1'b0; modelOn = 1'b1; masterMode = 1'b1; fmtI2s = fmt; speedSel = spd;
    mH = BH * ((spd == 2'd0) ? 4 : (spd == 2'd1) ? 2 : 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < frames * 2 * HS * 2 * mH; c++) begin
      @(negedge clk);
      if (c % 87 == 0) begin
        leftSample = 24'h800000; rightSample = 24'h7FFFFF;
      end else if (c % 29 == 0) begin
        seed = nextSeed(seed); leftSample = seed[SW-1:0];
        seed = nextSeed(seed); rightSample = seed[SW+3:4];
      end
    end
    modelOn = 1'b0;
  endtask

  task automatic runSlave(input bit fmt, input int perHalf, input int frames);
    logic [SW-1:0] l, r;
    @(negedge clk);
    rstN = 1'b0; modelOn = 1'b0; masterMode = 1'b0; fmtI2s = fmt;
    sclkIn = 1'b1; lrckIn = fmt;   // right-channel level
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    slaveLoads = 0;
    for (int f = 0; f < frames; f++) begin
      seed = nextSeed(seed); l = (f == 0) ? 24'hA5C3_0F : seed[SW-1:0];
      seed = nextSeed(seed); r = (f == 0) ? 24'h000001 : seed[SW+5:6];
      leftSample = l; rightSample = r;
      for (int h = 0; h < 2; h++) begin
        for (int pos = 0; pos < perHalf; pos++) begin
          bit e;
          sclkIn = 1'b0;
          if (pos == 0) lrckIn = (h == 0) ? !fmt : fmt;
          if (h == 0 && pos == 5) begin leftSample = ~l; rightSample = ~r; end
          repeat (P-1) @(negedge clk);
          e = slotBit((h == 0) ? l : r, pos, fmt);
          chk(sdataOut == e, (pos >= SW) ? "R5" : "R8", "slave sdataOut", sdataOut, e);
          chk(bclkOut == 1'b1 && lrckOut == 1'b0, "R8", "idle clock pins", {bclkOut, lrckOut}, 2);
          @(negedge clk);
          sclkIn = 1'b1;
          repeat (P) @(negedge clk);
        end
      end
    end
    chk(slaveLoads == frames, "R9", "slave frame loads", slaveLoads, frames);
  endtask

  initial begin
    // R1: reset levels
    repeat (3) @(negedge clk);
    chk(bclkOut == 1'b1 && lrckOut == 1'b0 && sdataOut == 1'b0 && loadStrobe == 1'b0,
        "R1", "reset outputs", {bclkOut, lrckOut, sdataOut, loadStrobe}, 8);
    rstN = 1'b1;
    @(negedge clk);
    chk(bclkOut == 1'b1 && sdataOut == 1'b0, "R1", "before first edge", {bclkOut, sdataOut}, 2);

    runMaster(1'b0, 2'd2, 3);  // left-justified, quad
    runMaster(1'b1, 2'd0, 2);  // I2S, single
    runMaster(1'b0, 2'd1, 2);  // left-justified, double
    runMaster(1'b1, 2'd3, 2);  // I2S, alternate quad code
    runSlave(1'b0, 32, 2);     // left-justified, 64 bit clocks per frame
    runSlave(1'b1, 64, 2);     // I2S, 128 bit clocks per frame

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule